// File: doc/BRIEF.md
# Address bus request/grant controller

This block is the requesting side of address-bus arbitration for a processor bus where the address phase and the data phase are separate tenures. An internal transaction queue presents a pending transaction and may cancel it. The block then drives an active-low bus request and watches the external grant. When the grant is qualified, it opens an address tenure with a one-cycle active-low transfer-start pulse. It holds that tenure until the address acknowledge arrives, and at that point it pops the queue entry. An address retry, from any source, forces the request off for a programmable gap. A checkstop or a hard reset releases the request line to high impedance, which the block signals through a separate output enable.

A single state machine drives the behaviour. The states are ST_HOLD, ST_IDLE, ST_REQ, ST_START, ST_TENURE, ST_GAP and ST_HALT.

- ST_HOLD: the cycle after reset release, with the request off.
- ST_IDLE: no request driven. It goes to ST_REQ on a pending transaction while the grant is negated. It goes straight to ST_START when a pending transaction meets a qualified grant that is held while parked. It goes to ST_GAP on a retry.
- ST_REQ: request driven. It goes to ST_IDLE on a cancel or when the pending transaction goes away. It goes to ST_START on a qualified grant, and to ST_GAP on a retry.
- ST_START: the transfer-start pulse. It always goes to ST_TENURE.
- ST_TENURE: waiting for the acknowledge. It goes to ST_IDLE on the acknowledge, which pops the queue entry. It goes to ST_GAP on a retry, and the transaction stays pending.
- ST_GAP: counts the enforced quiet cycles, then goes to ST_IDLE. A fresh retry reloads the count.
- ST_HALT: entered from any state on a checkstop. Only reset leaves it.

A separate window tracker watches every transfer start on the bus, including the block's own. From that start until the acknowledge or retry that closes it, the tracker blocks the grant.

Top module: `addr_arb_ctrl`

## Requirements
- R1: `bus_req_n_o` goes low (active) only from ST_IDLE, and only when `req_valid_i`=1, `req_cancel_i`=0, no retry is present and `bus_grant_n_i`=1. It turns active in the next cycle. With no pending transaction, it stays high.
- R2: After a qualified grant is accepted, `bus_req_n_o` stays high during the transfer-start cycle and during the whole tenure, even with another transaction pending. It can turn active again no earlier than one cycle after the tenure ends.
- R3: When `addr_retry_n_i`=0 is sampled, `bus_req_n_o` is high in the following cycle. It stays high for GAP_CYCLES cycles, then for one more cycle in ST_IDLE, before it can turn active.
- R4: `req_cancel_i`=1 while requesting withdraws the request in the next cycle, and no transfer start follows.
- R5: A grant is ignored in any cycle where `bus_ts_n_i`=0, and in every cycle after that up to and including the cycle that samples `addr_ack_n_i`=0 or `addr_retry_n_i`=0. The block's own transfer start opens the same window.
- R6: A qualified grant is `bus_grant_n_i`=0 together with `addr_retry_n_i`=1 outside that window. It drives `xfer_start_n_o` low for exactly one cycle, starting in the next cycle.
- R7: The tenure stays open until `addr_ack_n_i`=0. `req_pop_o` is 1 combinationally in that acknowledge cycle only. If a retry (`addr_retry_n_i`=0) arrives during the tenure, it wins over an acknowledge: there is no pop, the transaction stays pending and arbitration restarts after the gap.
- R8: When the grant is held low while no request is driven (parked), a pending transaction starts directly with `xfer_start_n_o` low, and `bus_req_n_o` never goes low.
- R9: `bus_req_oe_o` is 0 while `rst_n`=0, and from the cycle after `chkstop_i`=1 is sampled until the next reset. After reset release, `bus_req_n_o` is high for the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Hard reset, active low |
| chkstop_i | input | 1 | Checkstop condition, active high |
| req_valid_i | input | 1 | Transaction pending in the internal queue |
| req_cancel_i | input | 1 | Internal cancellation of the pending request |
| req_pop_o | output | 1 | Tenure acknowledged; pop the queue entry |
| bus_req_n_o | output | 1 | Bus request, active low |
| bus_req_oe_o | output | 1 | Output enable for the bus request line (0 = high impedance) |
| bus_grant_n_i | input | 1 | Bus grant from the arbiter, active low |
| bus_ts_n_i | input | 1 | Transfer start seen on the bus from another master, active low |
| addr_ack_n_i | input | 1 | Address acknowledge, active low |
| addr_retry_n_i | input | 1 | Address retry, active low |
| xfer_start_n_o | output | 1 | Transfer start driven by this block, active low |

## Verification
The bench builds the block with GAP_CYCLES=2. This makes the post-retry quiet period longer than the minimum one-cycle gap after a grant, so a design that reuses one gap for both cases, or ends the gap early, shows a request one cycle too soon. A scoreboard records the cycle in which each completed tenure should pop the queue. It then checks that a retried tenure produces no pop, and that the cycles of the parked start and the ordinary start line up.

// File: rtl/addr_arb_pkg.sv
package addr_arb_pkg;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_IDLE   = 3'd1,
        ST_REQ    = 3'd2,
        ST_START  = 3'd3,
        ST_TENURE = 3'd4,
        ST_GAP    = 3'd5,
        ST_HALT   = 3'd6
    } arb_state_e;

endpackage

// File: rtl/addr_window_track.sv
module addr_window_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ts_seen_i,
    input  logic close_i,
    output logic block_o
);
    logic busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (close_i) begin
            busy_q <= 1'b0;
        end else if (ts_seen_i) begin
            busy_q <= 1'b1;
        end
    end

    assign block_o = busy_q | ts_seen_i;

    // R5: once a start was seen without a closing response, the next cycle is blocked
    a_r5_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_seen_i && !close_i) |=> block_o);

endmodule

// File: rtl/addr_arb_ctrl.sv
module addr_arb_ctrl
    import addr_arb_pkg::*;
#(
    parameter int GAP_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chkstop_i,
    input  logic req_valid_i,
    input  logic req_cancel_i,
    output logic req_pop_o,
    output logic bus_req_n_o,
    output logic bus_req_oe_o,
    input  logic bus_grant_n_i,
    input  logic bus_ts_n_i,
    input  logic addr_ack_n_i,
    input  logic addr_retry_n_i,
    output logic xfer_start_n_o
);
    localparam int CW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [CW-1:0] GAP_LOAD = CW'(GAP_CYCLES - 1);

    arb_state_e state_q, state_d;
    logic [CW-1:0] gap_q, gap_d;
    logic pending, retry, ack, grant_ok, win_block, own_ts;

    assign pending = req_valid_i & ~req_cancel_i;
    assign retry   = ~addr_retry_n_i;
    assign ack     = ~addr_ack_n_i;
    assign own_ts  = (state_q == ST_START);

    addr_window_track u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .ts_seen_i (~bus_ts_n_i | own_ts),
        .close_i   (ack | retry),
        .block_o   (win_block)
    );

    assign grant_ok = ~bus_grant_n_i & ~retry & ~win_block;

    // Next-state and gap counter
    always_comb begin
        state_d = state_q;
        gap_d   = gap_q;
        unique case (state_q)
            ST_HOLD: state_d = ST_IDLE;
            ST_IDLE: begin
                if (retry) begin
                    state_d = ST_GAP;
                    gap_d   = GAP_LOAD;
                end else if (pending && grant_ok) begin
                    state_d = ST_START;
                end else if (pending && bus_grant_n_i) begin
                    state_d = ST_REQ;
                end
            end
            ST_REQ: begin
                if (retry) begin
                    state_d = ST_GAP;
                    gap_d   = GAP_LOAD;
                end else if (!pending) begin
                    state_d = ST_IDLE;
                end else if (grant_ok) begin
                    state_d = ST_START;
                end
            end
            ST_START: state_d = ST_TENURE;
            ST_TENURE: begin
                if (retry) begin
                    state_d = ST_GAP;
                    gap_d   = GAP_LOAD;
                end else if (ack) begin
                    state_d = ST_IDLE;
                end
            end
            ST_GAP: begin
                if (retry) begin
                    gap_d = GAP_LOAD;
                end else if (gap_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    gap_d = gap_q - 1'b1;
                end
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
        if (chkstop_i) begin
            state_d = ST_HALT;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end

    // Outputs
    always_comb begin
        bus_req_n_o    = (state_q != ST_REQ);
        bus_req_oe_o   = rst_n & (state_q != ST_HALT);
        xfer_start_n_o = (state_q != ST_START);
        req_pop_o      = (state_q == ST_TENURE) & ack & ~retry;
    end

    // R1: no request without a pending transaction
    a_r1_req_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid_i && !chkstop_i) |=> bus_req_n_o);

    // R2: the request is off in the cycle after a transfer start
    a_r2_gap_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_start_n_o |=> bus_req_n_o);

    // R3: a sampled retry turns the request off in the next cycle
    a_r3_retry_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        retry |=> bus_req_n_o);

    // R4: a cancel withdraws the request and starts nothing
    a_r4_cancel_withdraws: assert property (@(posedge clk) disable iff (!rst_n)
        req_cancel_i |=> (bus_req_n_o && xfer_start_n_o));

    // R5: no start directly after a blocked cycle
    a_r5_no_start_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        win_block |=> xfer_start_n_o);

    // R6: the transfer start lasts exactly one cycle
    a_r6_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_start_n_o |=> xfer_start_n_o);

    // R7: the pop happens only together with an acknowledge
    a_r7_pop_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        req_pop_o |-> (ack && !retry));

    // R9: a checkstop releases the request line
    a_r9_chkstop_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        chkstop_i |=> !bus_req_oe_o);

endmodule

// File: tb/sim_addr_arb_ctrl.sv
module sim_addr_arb_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chkstop_i = 1'b0, req_valid_i = 1'b0, req_cancel_i = 1'b0;
    logic bus_grant_n_i = 1'b1, bus_ts_n_i = 1'b1, addr_ack_n_i = 1'b1, addr_retry_n_i = 1'b1;
    logic req_pop_o, bus_req_n_o, bus_req_oe_o, xfer_start_n_o;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;
    bit done = 1'b0;
    int exp_pop_q[$];

    always #2.5 clk = ~clk;

    addr_arb_ctrl #(.GAP_CYCLES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .chkstop_i(chkstop_i),
        .req_valid_i(req_valid_i), .req_cancel_i(req_cancel_i), .req_pop_o(req_pop_o),
        .bus_req_n_o(bus_req_n_o), .bus_req_oe_o(bus_req_oe_o),
        .bus_grant_n_i(bus_grant_n_i), .bus_ts_n_i(bus_ts_n_i),
        .addr_ack_n_i(addr_ack_n_i), .addr_retry_n_i(addr_retry_n_i),
        .xfer_start_n_o(xfer_start_n_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cyc_cnt);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Scoreboard monitor: the pop must come in the cycle the driver expects
    initial begin
        forever begin
            @(negedge clk);
            #2;
            cyc_cnt++;
            if (rst_n && req_pop_o === 1'b1) begin
                checks++;
                if (exp_pop_q.size() == 0) begin
                    errors++;
                    $display("FAIL R7: actual pop in cycle %0d expected no pop", cyc_cnt);
                end else begin
                    int e;
                    e = exp_pop_q.pop_front();
                    if (e != cyc_cnt) begin
                        errors++;
                        $display("FAIL R7: actual pop cycle %0d expected %0d", cyc_cnt, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (3) step();
        check("R9 oe in reset", bus_req_oe_o, 1'b0);
        rst_n = 1'b1; req_valid_i = 1'b1;
        step();
        check("R9 first cycle req", bus_req_n_o, 1'b1);
        check("R9 oe after reset", bus_req_oe_o, 1'b1);
        step();
        check("R1 request", bus_req_n_o, 1'b0);
        bus_grant_n_i = 1'b0;
        step();
        check("R6 start", xfer_start_n_o, 1'b0);
        check("R2 req off at start", bus_req_n_o, 1'b1);
        bus_grant_n_i = 1'b1;
        step();
        check("R6 start one cycle", xfer_start_n_o, 1'b1);
        check("R2 req off in tenure", bus_req_n_o, 1'b1);
        addr_ack_n_i = 1'b0;
        exp_pop_q.push_back(cyc_cnt + 1);
        step();
        addr_ack_n_i = 1'b1;
        check("R2 req off after ack", bus_req_n_o, 1'b1);
        step();
        check("R2 re-request", bus_req_n_o, 1'b0);
        // R3 retry during request
        addr_retry_n_i = 1'b0;
        step();
        addr_retry_n_i = 1'b1;
        check("R3 gap 1", bus_req_n_o, 1'b1);
        step();
        check("R3 gap 2", bus_req_n_o, 1'b1);
        step();
        check("R3 idle after gap", bus_req_n_o, 1'b1);
        step();
        check("R3 request again", bus_req_n_o, 1'b0);
        // R4 cancel
        req_cancel_i = 1'b1;
        step();
        check("R4 cancel drops req", bus_req_n_o, 1'b1);
        check("R4 no start", xfer_start_n_o, 1'b1);
        req_cancel_i = 1'b0; req_valid_i = 1'b0;
        step();
        check("R1 no pending", bus_req_n_o, 1'b1);
        // R5 window from another master
        req_valid_i = 1'b1;
        step();
        check("R1 request 2", bus_req_n_o, 1'b0);
        bus_ts_n_i = 1'b0; bus_grant_n_i = 1'b0;
        step();
        check("R5 grant in ts cycle ignored", xfer_start_n_o, 1'b1);
        check("R5 still requesting", bus_req_n_o, 1'b0);
        bus_ts_n_i = 1'b1;
        step();
        check("R5 grant in window ignored", xfer_start_n_o, 1'b1);
        addr_ack_n_i = 1'b0;
        #1 check("R7 no pop for foreign ack", req_pop_o, 1'b0);
        step();
        check("R5 grant in ack cycle ignored", xfer_start_n_o, 1'b1);
        addr_ack_n_i = 1'b1;
        step();
        check("R6 start after window", xfer_start_n_o, 1'b0);
        bus_grant_n_i = 1'b1;
        step();
        // R7 retry during own tenure
        addr_retry_n_i = 1'b0; addr_ack_n_i = 1'b0;
        #1 check("R7 retry beats ack", req_pop_o, 1'b0);
        step();
        addr_retry_n_i = 1'b1; addr_ack_n_i = 1'b1;
        check("R3 gap after tenure retry", bus_req_n_o, 1'b1);
        step();
        step();
        check("R7 idle before re-arb", bus_req_n_o, 1'b1);
        step();
        check("R7 re-arbitrate", bus_req_n_o, 1'b0);
        bus_grant_n_i = 1'b0;
        step();
        check("R6 start retried", xfer_start_n_o, 1'b0);
        step();
        addr_ack_n_i = 1'b0;
        exp_pop_q.push_back(cyc_cnt + 1);
        step();
        addr_ack_n_i = 1'b1;
        check("R8 parked idle no req", bus_req_n_o, 1'b1);
        step();
        check("R8 parked direct start", xfer_start_n_o, 1'b0);
        check("R8 no request when parked", bus_req_n_o, 1'b1);
        step();
        addr_ack_n_i = 1'b0;
        exp_pop_q.push_back(cyc_cnt + 1);
        step();
        addr_ack_n_i = 1'b1; req_valid_i = 1'b0; bus_grant_n_i = 1'b1;
        step();
        // R9 checkstop
        chkstop_i = 1'b1;
        step();
        check("R9 checkstop hiz", bus_req_oe_o, 1'b0);
        chkstop_i = 1'b0; req_valid_i = 1'b1;
        step();
        check("R9 stays hiz", bus_req_oe_o, 1'b0);
        check("R9 no request halted", bus_req_n_o, 1'b1);
        step();
        checks++;
        if (exp_pop_q.size() != 0) begin
            errors++;
            $display("FAIL R7: actual %0d pops missing expected 0", exp_pop_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule